// File: doc/BRIEF.md
# Framed Rate-1/2 Convolutional Encoder

This block turns a short message word into a convolutional codeword. A parallel message is captured on a start strobe. It is then shifted through a constraint-length-3, rate-1/2 encoder one bit per clock. Each message bit produces a two-bit code symbol. The symbols collect in an accumulating shift register. When the last message bit has been coded, the whole codeword is copied to the output and a single-cycle valid pulse marks it.

The encoder memory holds the two most recent message bits and is cleared at the start of every frame, so frames are coded independently. A start strobe that arrives while a frame is still being coded has no effect. The published codeword stays unchanged until the next frame completes, so a consumer may sample it at any time after the pulse.

Top module: `cenc_frame_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `valid_o` is 0 and `cw_o` is all zeros.
- R2: The upper bit of each symbol (bit 2k+1 of `cw_o`) equals the message bit XOR the previous message bit XOR the message bit two steps earlier (generator 1+D+D²).
- R3: The lower bit of each symbol (bit 2k of `cw_o`) equals the message bit XOR the message bit two steps earlier (generator 1+D²).
- R4: Message bits are coded MSB first. The symbol from the k-th coded bit (k = 0 for the MSB) occupies `cw_o[2k+1:2k]`, so the first symbol lands in the lowest two bits.
- R5: If `start_i` is sampled high on a clock edge while idle, `valid_o` goes high after exactly MSG_W further edges and stays high for one cycle only.
- R6: Both encoder memory bits are 0 when each frame starts, whatever the previous frame left in them.
- R7: A `start_i` sampled while a frame is being coded is ignored: neither the timing nor the codeword of the running frame changes.
- R8: `cw_o` changes only on the edge that raises `valid_o`, and holds its value otherwise.
- R9: A start sampled on the same edge as the valid pulse is visible on the outputs, or on any later idle edge, begins a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe; captures `msg_i` when idle |
| msg_i | input | MSG_W | Parallel message word, MSB coded first |
| cw_o | output | 2*MSG_W | Codeword, symbol k in bits [2k+1:2k] |
| valid_o | output | 1 | One-cycle pulse when `cw_o` is updated |

## Verification
The bench builds the block with the default MSG_W of 6, which makes the message space small enough to code every one of the 64 words. Every generator tap and every symbol position is therefore exercised against a bench-side model. Random frames add spurious start strobes at random points inside a frame, and chain frames back to back so that a start is issued on the valid cycle itself. A frame whose message leaves the memory at 11 is followed by an all-zero message, which shows that the memory is cleared between frames.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
    localparam int SYM_W = 2;
    localparam int MEM_W = 2;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic d1;
        logic d2;
    } mem_t;
endpackage

// File: rtl/cenc_loader.sv
module cenc_loader #(
    parameter int MSG_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [MSG_W-1:0] msg_i,
    input  logic             step_i,
    output logic             bit_o
);
    logic [MSG_W-1:0] msg_d, msg_q;

    always_comb begin
        msg_d = msg_q;
        if (load_i) begin
            msg_d = msg_i;
        end else if (step_i) begin
            msg_d = msg_q << 1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            msg_q <= '0;
        end else begin
            msg_q <= msg_d;
        end
    end

    assign bit_o = msg_q[MSG_W-1];
endmodule

// File: rtl/cenc_trellis.sv
module cenc_trellis
    import cenc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic step_i,
    input  logic bit_i,
    output sym_t sym_o
);
    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clear_i) begin
            mem_d = '0;
        end else if (step_i) begin
            mem_d.d2 = mem_q.d1;
            mem_d.d1 = bit_i;
        end
        sym_o[1] = bit_i ^ mem_q.d1 ^ mem_q.d2;
        sym_o[0] = bit_i ^ mem_q.d2;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R6: a frame starts from an all-zero memory
    a_r6_mem_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> (mem_q == '0));
endmodule

// File: rtl/cenc_packer.sv
module cenc_packer
    import cenc_pkg::*;
#(
    parameter int MSG_W = 6
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   step_i,
    input  logic                   last_i,
    input  sym_t                   sym_i,
    output logic [SYM_W*MSG_W-1:0] cw_o,
    output logic                   valid_o
);
    localparam int CW_W = SYM_W * MSG_W;

    typedef struct packed {
        logic [CW_W-1:0] acc;
        logic [CW_W-1:0] cw;
        logic            valid;
    } pack_t;

    pack_t pk_d, pk_q;
    logic [CW_W-1:0] shifted;

    always_comb begin
        shifted     = {sym_i, pk_q.acc[CW_W-1:SYM_W]};
        pk_d        = pk_q;
        pk_d.valid  = 1'b0;
        if (step_i) begin
            pk_d.acc = shifted;
            if (last_i) begin
                pk_d.cw    = shifted;
                pk_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign cw_o    = pk_q.cw;
    assign valid_o = pk_q.valid;

    // R8: the published codeword moves only with the valid pulse
    a_r8_cw_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(cw_o));

    // R5: the valid pulse is a single cycle wide
    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);
endmodule

// File: rtl/cenc_frame_top.sv
module cenc_frame_top
    import cenc_pkg::*;
#(
    parameter int MSG_W = 6
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   start_i,
    input  logic [MSG_W-1:0]       msg_i,
    output logic [SYM_W*MSG_W-1:0] cw_o,
    output logic                   valid_o
);
    localparam int CNT_W = (MSG_W > 1) ? $clog2(MSG_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MSG_W - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept, step, last, cur_bit;
    sym_t sym;

    always_comb begin
        accept = start_i && !ctl_q.busy;
        step   = ctl_q.busy;
        last   = ctl_q.busy && (ctl_q.cnt == LAST_IDX);
        ctl_d  = ctl_q;
        if (accept) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = '0;
        end else if (step) begin
            if (last) begin
                ctl_d.busy = 1'b0;
                ctl_d.cnt  = '0;
            end else begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cenc_loader #(.MSG_W(MSG_W)) loader_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (accept),
        .msg_i  (msg_i),
        .step_i (step),
        .bit_o  (cur_bit)
    );

    cenc_trellis trellis_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (accept),
        .step_i  (step),
        .bit_i   (cur_bit),
        .sym_o   (sym)
    );

    cenc_packer #(.MSG_W(MSG_W)) packer_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (step),
        .last_i  (last),
        .sym_i   (sym),
        .cw_o    (cw_o),
        .valid_o (valid_o)
    );

    // R7: a strobe during a frame does not restart the step count
    a_r7_count_advances: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_q.busy && (ctl_q.cnt != LAST_IDX)) |=>
            (ctl_q.busy && (ctl_q.cnt == $past(ctl_q.cnt) + CNT_W'(1))));

    // R5: the pulse follows the final coding step
    a_r5_valid_after_frame: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> ($past(ctl_q.busy) && ($past(ctl_q.cnt) == LAST_IDX)));

    // R1: outputs idle straight out of reset
    a_r1_reset_idle: assert property (@(posedge clk_i)
        $fell(rst_i) |-> (!valid_o && (cw_o == '0)));
endmodule

// File: tb/cenc_frame_top_tb_top.sv
module cenc_frame_top_tb_top;
    localparam int MSG_W = 6;
    localparam int CW_W  = 2 * MSG_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [MSG_W-1:0] msg;
    logic [CW_W-1:0]  cw;
    logic             valid;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cenc_frame_top #(.MSG_W(MSG_W)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .msg_i   (msg),
        .cw_o    (cw),
        .valid_o (valid)
    );

    function automatic logic [CW_W-1:0] model(input logic [MSG_W-1:0] m);
        logic s1 = 1'b0;
        logic s2 = 1'b0;
        logic [CW_W-1:0] r = '0;
        for (int k = 0; k < MSG_W; k++) begin
            logic b;
            b          = m[MSG_W-1-k];
            r[2*k+1]   = b ^ s1 ^ s2;
            r[2*k]     = b ^ s2;
            s2         = s1;
            s1         = b;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts a frame at a negedge and follows it to its valid cycle.
    // spur_at in 2..MSG_W injects an ignored strobe (R7); chain starts the
    // next frame on the valid cycle (R9).
    task automatic frame(input logic [MSG_W-1:0] m, input int spur_at,
                         input bit chain, input logic [MSG_W-1:0] next_m,
                         input string req);
        logic [CW_W-1:0] prev_cw;
        prev_cw = cw;
        start = 1'b1;
        msg   = m;
        for (int i = 1; i <= MSG_W + 1; i++) begin
            @(negedge clk);
            start = 1'b0;
            msg   = $urandom;
            if (i == spur_at) start = 1'b1;
            if (i <= MSG_W) begin
                check(valid == 1'b0, "R5 early valid", valid, 0);
                check(cw == prev_cw, "R8 cw held", cw, prev_cw);
            end
        end
        check(valid == 1'b1, "R5 valid pulse", valid, 1);
        check(cw == model(m), req, cw, model(m));
        if (chain) begin
            start = 1'b1;
            msg   = next_m;
        end
    endtask

    task automatic after_frame(input logic [CW_W-1:0] exp_cw);
        @(negedge clk);
        start = 1'b0;
        check(valid == 1'b0, "R5 pulse one cycle", valid, 0);
        check(cw == exp_cw, "R8 cw held after pulse", cw, exp_cw);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst   = 1'b1;
        start = 1'b0;
        msg   = '0;
        repeat (3) @(negedge clk);
        check(valid == 1'b0 && cw == '0, "R1 reset state", {valid, cw}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(valid == 1'b0 && cw == '0, "R1 after reset", {valid, cw}, 0);

        // directed: impulse shows both taps and symbol order
        frame(6'b100000, 0, 0, '0, "R2 R3 R4 impulse 0x03b");
        check(cw == 12'h03b, "R4 impulse literal", cw, 12'h03b);
        after_frame(12'h03b);
        frame(6'b100100, 0, 0, '0, "R2 R3 pattern 100100");
        check(cw == 12'hefb, "R2 literal 0xefb", cw, 12'hefb);
        after_frame(12'hefb);
        frame(6'b111111, 0, 0, '0, "R3 all ones");
        check(cw == 12'haa7, "R3 literal 0xaa7", cw, 12'haa7);
        after_frame(12'haa7);

        // R6: memory left at 11, then all-zero message must give zero
        frame(6'b000011, 0, 1, 6'b000000, "R6 leaves memory set");
        frame(6'b000000, 0, 0, '0, "R6 R9 cleared memory, chained start");
        check(cw == '0, "R6 zero codeword", cw, 0);
        after_frame('0);

        // R7: strobes inside a frame at every position
        for (int p = 2; p <= MSG_W; p++) begin
            frame(6'b101101, p, 0, '0, "R7 spurious start ignored");
            after_frame(model(6'b101101));
        end

        // exhaustive messages, random spurious strobes, some chained
        for (int v = 0; v < (1 << MSG_W); v++) begin
            int sp;
            sp = ($urandom % 3 == 0) ? 2 + ($urandom % (MSG_W - 1)) : 0;
            frame(MSG_W'(v), sp, 0, '0, "R2 R3 R4 exhaustive");
            after_frame(model(MSG_W'(v)));
        end
        for (int n = 0; n < 20; n++) begin
            logic [MSG_W-1:0] a, b;
            a = $urandom;
            b = $urandom;
            frame(a, 0, 1, b, "R9 chain first");
            frame(b, 2 + ($urandom % (MSG_W - 1)), 0, '0, "R9 chain second");
            after_frame(model(b));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule